// File: doc/BRIEF.md
# Vertical Divider Field-Rate Controller

This block paces vertical deflection from a half-line enable. A counter advances once for every enable, so each count is half a video line. A state machine uses that count to decide when each field ends. When the incoming vertical timing is trusted, it issues the vertical sync pulse itself. When the timing is less trusted, it follows the separated vertical sync input, bounded by a search window and a timeout. A saturating up/down score of recent fields sets the level of trust.

The block either finds the field rate (50 or 60 Hz) by itself or has the rate forced by two control pins. All pins are plain control and status signals. No data stream passes through the block, so it needs no valid/ready handshake and applies no back-pressure. The state is brought out for debug with a fixed encoding.

Top module: `vdiv_field_ctrl`

## Requirements
- R1: The half-line counter starts at 0 after each field restart and gains one per `hp_en`. On the enable that finds it at 488, the controller leaves COUNT. It goes to NORM if the score is 7, to NEAR if the score is 4 to 6, and to SEARCH if the score is below 4. The `state_dbg` encoding is COUNT=0, NORM=1, NEAR=2, SEARCH=3, HOLD=4.
- R2: In NORM, the enable that finds the counter at the side's end value (626 for 50 Hz, 526 for 60 Hz) moves the controller to HOLD. The next enable restarts the field. A 50 Hz NORM field is therefore 628 enables long, whatever the sync input does.
- R3: In NEAR, a sync rising edge seen while the count lies strictly inside the side's window (622..628 for 50 Hz, 522..528 for 60 Hz) restarts the field on the next enable. A rising edge outside the window has no effect. With no such edge, the field restarts on the enable that finds the counter at the upper window bound.
- R4: In SEARCH, any sync rising edge restarts the field on the next enable. With no edge, the field times out at count 722 when `pll_locked` is high and a force pin is set. Otherwise it times out at the upper window bound.
- R5: `vsp_out` is high for exactly one clock after each field restart. That same enable returns the counter to 0 and the state to COUNT.
- R6: At each restart the score saturates between 0 and 7. It rises by one if an in-window sync edge was seen in the field and counted as good. Otherwise it falls by one.
- R7: In a field that was in NORM or NEAR, an in-window edge that follows a field without one counts as bad. Only the next good field raises the score.
- R8: `rate_60` reports the active side (1 = 60 Hz). `force_60` holds it at 1 and takes priority over `force_50`, which holds it at 0. While a force pin is set, the automatic side follows the forced side.
- R9: In automatic mode, the side switches at the restart that ends the 4th consecutive field whose edge fell in the other side's window and not in its own. The switch clears the score to 0.
- R10: After reset the state is COUNT, the score is 0, the side is 50 Hz and `vsp_out` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| hp_en | input | 1 | Half-line enable, one clock wide |
| vsync_in | input | 1 | Separated vertical sync level; its rising edge is used |
| pll_locked | input | 1 | Line phase loop is locked |
| force_50 | input | 1 | Hold the 50 Hz side |
| force_60 | input | 1 | Hold the 60 Hz side (wins over force_50) |
| vsp_out | output | 1 | Generated vertical sync pulse, one clock per field |
| rate_60 | output | 1 | Active field rate, 1 = 60 Hz |
| state_dbg | output | 3 | Controller state, encoded as in R1 |

## Verification
The bench goes after the one-count boundaries: the branch from COUNT, the NORM end and hold step, and the timeout on the enable that finds the bound. An off-by-one design would show field lengths one enable off. It plays a good field after a bad one in NEAR. A design without the penalty would score it as good and reach NORM one field too early. It also checks that an out-of-window edge in NEAR is ignored, where a wrong design would cut the field short. It counts four fields that land in the other side's window; switching on the third or fifth field would show up in `rate_60`. Under forcing it checks the long timeout and that a locked loop without forcing keeps the short one.

// File: rtl/vdiv_pkg.sv
`timescale 1ns/1ps
package vdiv_pkg;
  typedef enum logic [2:0] {
    ST_COUNT  = 3'd0,
    ST_NORM   = 3'd1,
    ST_NEAR   = 3'd2,
    ST_SEARCH = 3'd3,
    ST_HOLD   = 3'd4
  } vdiv_state_e;

  typedef enum logic [1:0] {
    CLS_SEARCH = 2'd0,
    CLS_NEAR   = 2'd1,
    CLS_NORM   = 2'd2
  } vdiv_class_e;
endpackage

// File: rtl/vdiv_half_line_counter.sv
`timescale 1ns/1ps
module vdiv_half_line_counter #(
  parameter int CNT_W = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             step,
  input  logic             clear,
  output logic [CNT_W-1:0] count
);
  localparam logic [CNT_W-1:0] CNT_TOP = '1;

  always_ff @(posedge clk) begin
    if (!rst_n)                         count <= '0;
    else if (clear)                     count <= '0;
    else if (step && count != CNT_TOP)  count <= count + 1'b1;
  end
endmodule

// File: rtl/vdiv_field_fsm.sv
`timescale 1ns/1ps
module vdiv_field_fsm
  import vdiv_pkg::*;
#(
  parameter int CNT_W     = 10,
  parameter int BRANCH_AT = 488
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             step,
  input  logic             sync_rise,
  input  logic             in_own,
  input  logic [CNT_W-1:0] count,
  input  logic [CNT_W-1:0] norm_end,
  input  logic [CNT_W-1:0] win_hi,
  input  logic [CNT_W-1:0] tmo_lim,
  input  vdiv_class_e      cls,
  output vdiv_state_e      state,
  output logic             restart
);
  localparam logic [CNT_W-1:0] BRANCH_CNT = CNT_W'(BRANCH_AT);

  logic pending;
  logic timeout;

  assign timeout = (state == ST_NEAR   && count == win_hi) ||
                   (state == ST_SEARCH && count == tmo_lim);
  assign restart = step && (state == ST_HOLD || pending || timeout);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state <= ST_COUNT;
    end else if (restart) begin
      state <= ST_COUNT;
    end else if (step) begin
      case (state)
        ST_COUNT: if (count == BRANCH_CNT) begin
          case (cls)
            CLS_NORM: state <= ST_NORM;
            CLS_NEAR: state <= ST_NEAR;
            default:  state <= ST_SEARCH;
          endcase
        end
        ST_NORM: if (count == norm_end) state <= ST_HOLD;
        default: state <= state;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)       pending <= 1'b0;
    else if (restart) pending <= 1'b0;
    else if (sync_rise && ((state == ST_NEAR && in_own) || state == ST_SEARCH))
      pending <= 1'b1;
  end
endmodule

// File: rtl/vdiv_norm_tracker.sv
`timescale 1ns/1ps
module vdiv_norm_tracker
  import vdiv_pkg::*;
#(
  parameter int NORM_W        = 3,
  parameter int NEAR_MIN      = 4,
  parameter int SWITCH_FIELDS = 4
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        sync_rise,
  input  logic        in_own,
  input  logic        in_oth,
  input  logic        restart,
  input  vdiv_state_e state,
  input  logic        forced,
  input  logic        side_eff,
  output vdiv_class_e cls,
  output logic        auto_side
);
  localparam logic [NORM_W-1:0] NORM_MAX = '1;
  localparam logic [NORM_W-1:0] NEAR_LIM = NORM_W'(NEAR_MIN);
  localparam int ALT_W = $clog2(SWITCH_FIELDS + 1);
  localparam logic [ALT_W-1:0] ALT_LAST = ALT_W'(SWITCH_FIELDS - 1);

  logic [NORM_W-1:0] score, score_n;
  logic [ALT_W-1:0]  alt, alt_n;
  logic hit_own, hit_oth, prev_bad, side_n, good;

  always_comb begin
    if (score == NORM_MAX)       cls = CLS_NORM;
    else if (score >= NEAR_LIM)  cls = CLS_NEAR;
    else                         cls = CLS_SEARCH;
  end

  assign good = hit_own && !(prev_bad && (state == ST_NORM || state == ST_NEAR));

  always_comb begin
    score_n = score;
    alt_n   = alt;
    side_n  = forced ? side_eff : auto_side;
    if (restart) begin
      if (good && score != NORM_MAX)   score_n = score + 1'b1;
      else if (!good && score != '0)   score_n = score - 1'b1;
      if (forced) begin
        alt_n = '0;
      end else if (hit_oth && !hit_own) begin
        if (alt == ALT_LAST) begin
          alt_n   = '0;
          side_n  = ~auto_side;
          score_n = '0;
        end else begin
          alt_n = alt + 1'b1;
        end
      end else begin
        alt_n = '0;
      end
    end else if (forced) begin
      alt_n = '0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      score     <= '0;
      alt       <= '0;
      auto_side <= 1'b0;
      prev_bad  <= 1'b0;
      hit_own   <= 1'b0;
      hit_oth   <= 1'b0;
    end else begin
      score     <= score_n;
      alt       <= alt_n;
      auto_side <= side_n;
      if (restart) begin
        prev_bad <= !hit_own;
        hit_own  <= 1'b0;
        hit_oth  <= 1'b0;
      end else if (sync_rise) begin
        if (in_own) hit_own <= 1'b1;
        if (in_oth) hit_oth <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/vdiv_field_ctrl.sv
`timescale 1ns/1ps
module vdiv_field_ctrl
  import vdiv_pkg::*;
#(
  parameter int CNT_W         = 10,
  parameter int BRANCH_AT     = 488,
  parameter int END_50        = 626,
  parameter int END_60        = 526,
  parameter int WLO_50        = 622,
  parameter int WHI_50        = 628,
  parameter int WLO_60        = 522,
  parameter int WHI_60        = 528,
  parameter int LONG_TMO      = 722,
  parameter int NORM_W        = 3,
  parameter int NEAR_MIN      = 4,
  parameter int SWITCH_FIELDS = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       hp_en,
  input  logic       vsync_in,
  input  logic       pll_locked,
  input  logic       force_50,
  input  logic       force_60,
  output logic       vsp_out,
  output logic       rate_60,
  output logic [2:0] state_dbg
);
  typedef struct packed {
    logic [CNT_W-1:0] lo;
    logic [CNT_W-1:0] hi;
    logic [CNT_W-1:0] fin;
  } side_lim_t;

  localparam side_lim_t LIM_50 = '{CNT_W'(WLO_50), CNT_W'(WHI_50), CNT_W'(END_50)};
  localparam side_lim_t LIM_60 = '{CNT_W'(WLO_60), CNT_W'(WHI_60), CNT_W'(END_60)};

  logic             vs_q, sync_rise;
  logic             forced, side_eff, auto_side;
  logic             in_own, in_oth, restart;
  logic [CNT_W-1:0] count, tmo_lim;
  side_lim_t        own, oth;
  vdiv_state_e      state;
  vdiv_class_e      cls;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vs_q    <= 1'b0;
      vsp_out <= 1'b0;
    end else begin
      vs_q    <= vsync_in;
      vsp_out <= restart;
    end
  end

  assign sync_rise = vsync_in && !vs_q;
  assign forced    = force_50 || force_60;
  assign side_eff  = force_60 ? 1'b1 : (force_50 ? 1'b0 : auto_side);

  assign own     = side_eff ? LIM_60 : LIM_50;
  assign oth     = side_eff ? LIM_50 : LIM_60;
  assign in_own  = (count > own.lo) && (count < own.hi);
  assign in_oth  = (count > oth.lo) && (count < oth.hi);
  assign tmo_lim = (pll_locked && forced) ? CNT_W'(LONG_TMO) : own.hi;

  vdiv_half_line_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .step(hp_en), .clear(restart), .count(count)
  );

  vdiv_field_fsm #(.CNT_W(CNT_W), .BRANCH_AT(BRANCH_AT)) u_fsm (
    .clk(clk), .rst_n(rst_n), .step(hp_en), .sync_rise(sync_rise),
    .in_own(in_own), .count(count), .norm_end(own.fin), .win_hi(own.hi),
    .tmo_lim(tmo_lim), .cls(cls), .state(state), .restart(restart)
  );

  vdiv_norm_tracker #(
    .NORM_W(NORM_W), .NEAR_MIN(NEAR_MIN), .SWITCH_FIELDS(SWITCH_FIELDS)
  ) u_trk (
    .clk(clk), .rst_n(rst_n), .sync_rise(sync_rise), .in_own(in_own),
    .in_oth(in_oth), .restart(restart), .state(state), .forced(forced),
    .side_eff(side_eff), .cls(cls), .auto_side(auto_side)
  );

  assign rate_60   = side_eff;
  assign state_dbg = state;
endmodule

// File: rtl/vdiv_field_ctrl_checker.sv
`timescale 1ns/1ps
module vdiv_field_ctrl_checker (
  input logic       clk,
  input logic       rst_n,
  input logic       force_50,
  input logic       force_60,
  input logic       vsp_out,
  input logic       rate_60,
  input logic [2:0] state_dbg
);
  assert_state_legal_R1: assert property (@(posedge clk) disable iff (!rst_n)
    state_dbg <= 3'd4);

  assert_branch_target_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (state_dbg != 3'd0 && $past(state_dbg) == 3'd0) |->
      (state_dbg == 3'd1 || state_dbg == 3'd2 || state_dbg == 3'd3));

  assert_hold_from_norm_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (state_dbg == 3'd4 && $past(state_dbg) != 3'd4) |-> $past(state_dbg) == 3'd1);

  assert_vsp_single_R5: assert property (@(posedge clk) disable iff (!rst_n)
    vsp_out |=> !vsp_out);

  assert_vsp_in_count_R5: assert property (@(posedge clk) disable iff (!rst_n)
    vsp_out |-> state_dbg == 3'd0);

  assert_force60_R8: assert property (@(posedge clk) disable iff (!rst_n)
    force_60 |-> rate_60);

  assert_force50_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (force_50 && !force_60) |-> !rate_60);
endmodule

bind vdiv_field_ctrl vdiv_field_ctrl_checker u_chk (
  .clk(clk), .rst_n(rst_n), .force_50(force_50), .force_60(force_60),
  .vsp_out(vsp_out), .rate_60(rate_60), .state_dbg(state_dbg)
);

// File: tb/vdiv_field_ctrl_bench.sv
`timescale 1ns/1ps
module vdiv_field_ctrl_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic hp_en = 1'b0;
  logic vsync_in = 1'b0;
  logic pll_locked = 1'b0;
  logic force_50 = 1'b0;
  logic force_60 = 1'b0;
  logic vsp_out, rate_60;
  logic [2:0] state_dbg;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  vdiv_field_ctrl u_vdiv_field_ctrl (
    .clk(clk), .rst_n(rst_n), .hp_en(hp_en), .vsync_in(vsync_in),
    .pll_locked(pll_locked), .force_50(force_50), .force_60(force_60),
    .vsp_out(vsp_out), .rate_60(rate_60), .state_dbg(state_dbg)
  );

  // {force(2: 0 none,1 fifty,2 sixty), locked, sync_at(0 none), exp_state, exp_rate, exp_len}
  localparam int NV = 31;
  localparam logic [26:0] VECS [NV] = '{
    {2'd0,1'b0,10'd625,3'd3,1'b0,10'd626},
    {2'd0,1'b0,10'd625,3'd3,1'b0,10'd626},
    {2'd0,1'b0,10'd625,3'd3,1'b0,10'd626},
    {2'd0,1'b0,10'd625,3'd3,1'b0,10'd626},
    {2'd0,1'b0,10'd625,3'd2,1'b0,10'd626},
    {2'd0,1'b0,10'd625,3'd2,1'b0,10'd626},
    {2'd0,1'b0,10'd625,3'd2,1'b0,10'd626},
    {2'd0,1'b0,10'd625,3'd1,1'b0,10'd628},
    {2'd0,1'b0,10'd0,  3'd1,1'b0,10'd628},
    {2'd0,1'b0,10'd625,3'd2,1'b0,10'd626},
    {2'd0,1'b0,10'd625,3'd2,1'b0,10'd626},
    {2'd0,1'b0,10'd0,  3'd2,1'b0,10'd629},
    {2'd0,1'b0,10'd600,3'd2,1'b0,10'd629},
    {2'd0,1'b0,10'd624,3'd2,1'b0,10'd625},
    {2'd0,1'b0,10'd540,3'd3,1'b0,10'd541},
    {2'd0,1'b0,10'd0,  3'd3,1'b0,10'd629},
    {2'd0,1'b0,10'd525,3'd3,1'b0,10'd526},
    {2'd0,1'b0,10'd525,3'd3,1'b0,10'd526},
    {2'd0,1'b0,10'd525,3'd3,1'b0,10'd526},
    {2'd0,1'b0,10'd525,3'd3,1'b0,10'd526},
    {2'd0,1'b0,10'd525,3'd3,1'b1,10'd526},
    {2'd0,1'b0,10'd0,  3'd3,1'b1,10'd529},
    {2'd1,1'b1,10'd0,  3'd3,1'b0,10'd723},
    {2'd1,1'b1,10'd525,3'd3,1'b0,10'd526},
    {2'd1,1'b1,10'd525,3'd3,1'b0,10'd526},
    {2'd1,1'b1,10'd525,3'd3,1'b0,10'd526},
    {2'd1,1'b1,10'd525,3'd3,1'b0,10'd526},
    {2'd1,1'b1,10'd525,3'd3,1'b0,10'd526},
    {2'd0,1'b1,10'd0,  3'd3,1'b0,10'd629},
    {2'd2,1'b1,10'd525,3'd3,1'b1,10'd526},
    {2'd2,1'b1,10'd0,  3'd3,1'b1,10'd723}
  };

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // One field: pulses hp_en until vsp_out appears, samples state and rate at count 510.
  task automatic run_field(input int sync_at, output int len, output int st, output int rt);
    int n = 0;
    len = 0; st = -1; rt = -1;
    while (len == 0 && n < 1000) begin
      hp_en = 1'b1;
      @(negedge clk);
      hp_en = 1'b0;
      n++;
      if (vsp_out) len = n;
      if (n == 510) begin st = int'(state_dbg); rt = int'(rate_60); end
      if (n == sync_at && len == 0) vsync_in = 1'b1;
      @(negedge clk);
      vsync_in = 1'b0;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    int len, st, rt;
    repeat (3) @(negedge clk);
    check(state_dbg == 3'd0, "R10 state", state_dbg, 0);
    check(rate_60 == 1'b0, "R10 rate", rate_60, 0);
    check(vsp_out == 1'b0, "R10 vsp", vsp_out, 0);
    rst_n = 1'b1;
    @(negedge clk);

    for (int i = 0; i < NV; i++) begin
      force_50   = (VECS[i][26:25] == 2'd1);
      force_60   = (VECS[i][26:25] == 2'd2);
      pll_locked = VECS[i][24];
      run_field(int'(VECS[i][23:14]), len, st, rt);
      check(st == int'(VECS[i][13:11]), "R1 R6 R7 state", st, int'(VECS[i][13:11]));
      check(rt == int'(VECS[i][10]), "R8 R9 rate", rt, int'(VECS[i][10]));
      check(len == int'(VECS[i][9:0]), "R2 R3 R4 R5 length", len, int'(VECS[i][9:0]));
    end

    // Directed: reset in the middle of a field clears state, side and score (R10).
    force_50 = 1'b0; force_60 = 1'b0; pll_locked = 1'b0;
    for (int k = 0; k < 300; k++) begin
      hp_en = 1'b1; @(negedge clk); hp_en = 1'b0; @(negedge clk);
    end
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    check(state_dbg == 3'd0, "R10 mid reset state", state_dbg, 0);
    check(vsp_out == 1'b0, "R10 mid reset vsp", vsp_out, 0);
    rst_n = 1'b1;
    @(negedge clk);
    run_field(0, len, st, rt);
    check(st == 3, "R10 R1 search after reset", st, 3);
    check(rt == 0, "R10 rate after reset", rt, 0);
    check(len == 629, "R4 short timeout after reset", len, 629);

    // Directed: both force pins high, sixty wins (R8).
    force_50 = 1'b1; force_60 = 1'b1;
    @(negedge clk);
    check(rate_60 == 1'b1, "R8 sixty priority", rate_60, 1);

    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule